// File: doc/BRIEF.md
# Converter Protection and Auto-Restart Sequencer

This block decides when the power switch of an off-line converter may run. It watches per-cycle reports from the PWM stage: a cycle cut short by the drain current limit, and a cycle cut short by the maximum duty limit. It also watches level flags from the analog front end: a supply clamp carrying too much current, the disable pin above its threshold, over-temperature, and a timeout raised when the switching frequency has sat at its floor. Each kind of event is filtered or counted. Once one of them qualifies as a fault, the block drops the PWM enable, records a cause code, and waits a fixed restart time.

Once the wait ends, the block restarts switching through an eight-step soft-start of the peak current setpoint. A thermal trip is handled differently. It first requests one probe switching cycle so that the temperature can be checked. If the chip is still hot, the block waits again. Otherwise it enters soft-start. A synchronous start input from the supply controller gates the whole sequence. When that input is lost, the block stops at once and forgets all history.

Top module: `prot_restart_seq`

## Requirements
- R1: Whenever `start_i` is low at a clock edge, after that edge `pwm_en_o`=0, `ilim_lvl_o`=0, `probe_o`=0 and `cause_o`=0, and every event counter restarts from zero.
- R2: On the first edge with `start_i` high from the off state, a soft-start begins. `ilim_lvl_o` takes the values 0,1,…,7, each held for SS_STEP_CLK clocks with `pwm_en_o`=1, and then stays at 7 in run. Level k stands for a setpoint of (k+1)/8 of full scale.
- R3: An overload counter moves only while switching, on `cyc_end_i` pulses. It counts up on a pulse with `cyc_ocp_i`=1 and down on one without, and it never goes below zero. A trip occurs on the pulse that brings the count to OVL_CYC (cause 5).
- R4: DMAX_RUN consecutive cycle-end pulses with `cyc_dmax_i`=1 cause a trip (cause 6). A cycle-end pulse without it restarts the run.
- R5: `clamp_i` trips only in run, and only after it has been high on more than CLAMP_HOLD consecutive edges (cause 3). During soft-start it has no effect.
- R6: `dis_i` trips after it has been high on more than DIS_HOLD consecutive edges while switching (cause 2). The following wait lasts DIS_RESTART_CLK clocks.
- R7: After any trip other than disable, `pwm_en_o` stays low for exactly RESTART_CLK clocks, even if the fault has cleared. Switching then restarts from soft-start level 0.
- R8: `ot_i` high while switching trips at once (cause 1). After the wait, `probe_o`=1 and `pwm_en_o`=1 until the next cycle-end pulse. If `ot_i` is then high, a new RESTART_CLK wait follows; if not, soft-start follows.
- R9: `floor_to_i` high while switching trips at once (cause 4) and uses the RESTART_CLK wait.
- R10: `cause_o` latches at trip time and keeps its value through the wait, the probe and the soft-start. It returns to 0 when a soft-start completes. When several trips coincide, the lower code wins: 1 thermal, 2 disable, 3 clamp, 4 floor, 5 overload, 6 max duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | supply controller allows operation (synchronous level) |
| cyc_end_i | input | 1 | one-clock pulse at the end of each switching cycle |
| cyc_ocp_i | input | 1 | qualifies `cyc_end_i`: the cycle ended on current limit |
| cyc_dmax_i | input | 1 | qualifies `cyc_end_i`: the cycle ended on maximum duty |
| clamp_i | input | 1 | supply clamp current above limit |
| dis_i | input | 1 | disable pin above threshold |
| ot_i | input | 1 | over-temperature flag |
| floor_to_i | input | 1 | frequency-floor timeout fault |
| pwm_en_o | output | 1 | PWM switching allowed |
| ilim_lvl_o | output | LVL_W | soft-start current-limit step |
| probe_o | output | 1 | single thermal probe cycle requested |
| cause_o | output | 3 | latched fault cause code |

## Verification
The bench shrinks every time constant. The overload limit is 6 cycles, the max-duty run stays at 10, the clamp hold is 5 and the disable hold is 8 clocks. The restart waits are 40 and 20 clocks, and each soft-start step lasts 3 clocks. With these values a single run can reach several full trip–wait–soft-start loops, a repeated thermal probe, and both sides of every debounce and count boundary (one short of tripping, and exactly tripping). The small overload limit also makes it easy to test that the counter saturates at zero, by sending clean cycles before the overcurrent burst.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [2:0] {
    C_NONE  = 3'd0,
    C_THERM = 3'd1,
    C_DIS   = 3'd2,
    C_CLAMP = 3'd3,
    C_FLOOR = 3'd4,
    C_OVL   = 3'd5,
    C_DMAX  = 3'd6
  } cause_e;

  typedef enum logic [2:0] {
    S_OFF, S_SOFT, S_RUN, S_WAIT, S_PROBE
  } seq_e;

  // milliseconds to ticks of a clock given in kHz
  function automatic int ms_to_ticks(int ms, int khz);
    return ms * khz;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // trips[0]=thermal .. trips[5]=max duty; lowest index wins, code = index+1
  function automatic cause_e pick_cause(logic [5:0] trips);
    cause_e c;
    c = C_NONE;
    for (int i = 5; i >= 0; i--)
      if (trips[i]) c = cause_e'(3'(i + 1));
    return c;
  endfunction

endpackage

// File: rtl/prot_level_filter.sv
module prot_level_filter #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl_i,
  output logic trip_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (!en || !lvl_i)    run_cnt <= '0;
    else if (run_cnt != CW'(HOLD)) run_cnt <= run_cnt + 1'b1;
  end

  assign trip_o = en && lvl_i && (run_cnt == CW'(HOLD));
endmodule

// File: rtl/prot_cycle_counter.sv
module prot_cycle_counter #(
  parameter int LIMIT  = 10,
  parameter bit UPDOWN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_i,
  input  logic hit_i,
  output logic trip_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  generate
    if (UPDOWN) begin : g_updown
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!en) cnt <= '0;
        else if (cyc_i) begin
          if (hit_i) begin
            if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end else begin : g_run
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!en) cnt <= '0;
        else if (cyc_i) begin
          if (!hit_i)                 cnt <= '0;
          else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate

  assign trip_o = en && cyc_i && hit_i && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/prot_restart_seq.sv
module prot_restart_seq #(
  parameter int LVL_W           = 3,
  parameter int CLK_KHZ         = 50000,
  parameter int FOSC_KHZ        = 60,
  parameter int OVL_CYC         = prot_pkg::ms_to_ticks(50, FOSC_KHZ),
  parameter int DMAX_RUN        = 10,
  parameter int CLAMP_HOLD      = CLK_KHZ / 2,
  parameter int DIS_HOLD        = prot_pkg::ms_to_ticks(1, CLK_KHZ),
  parameter int RESTART_CLK     = prot_pkg::ms_to_ticks(1000, CLK_KHZ),
  parameter int DIS_RESTART_CLK = prot_pkg::ms_to_ticks(500, CLK_KHZ),
  parameter int SS_STEP_CLK     = prot_pkg::ms_to_ticks(1, CLK_KHZ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cyc_end_i,
  input  logic             cyc_ocp_i,
  input  logic             cyc_dmax_i,
  input  logic             clamp_i,
  input  logic             dis_i,
  input  logic             ot_i,
  input  logic             floor_to_i,
  output logic             pwm_en_o,
  output logic [LVL_W-1:0] ilim_lvl_o,
  output logic             probe_o,
  output logic [2:0]       cause_o
);
  import prot_pkg::*;

  localparam int TMAX = max3(RESTART_CLK, DIS_RESTART_CLK, SS_STEP_CLK);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  seq_e            state;
  logic [TW-1:0]   tmr;
  logic [LVL_W-1:0] step;
  cause_e          cause;

  // named internal events
  logic       sw_active, run_only;
  logic [5:0] trips;
  logic       trip_any;
  cause_e     trip_cause;
  logic       ss_step_done, wait_done;
  logic [TW-1:0] wait_last;

  assign sw_active = (state == S_SOFT) || (state == S_RUN);
  assign run_only  = (state == S_RUN);

  assign trips[0] = sw_active && ot_i;
  assign trips[3] = sw_active && floor_to_i;

  prot_level_filter #(.HOLD(DIS_HOLD)) u_dis_flt (
    .clk(clk), .rst_n(rst_n), .en(sw_active), .lvl_i(dis_i), .trip_o(trips[1]));

  prot_level_filter #(.HOLD(CLAMP_HOLD)) u_clamp_flt (
    .clk(clk), .rst_n(rst_n), .en(run_only), .lvl_i(clamp_i), .trip_o(trips[2]));

  prot_cycle_counter #(.LIMIT(OVL_CYC), .UPDOWN(1'b1)) u_ovl_cnt (
    .clk(clk), .rst_n(rst_n), .en(sw_active), .cyc_i(cyc_end_i),
    .hit_i(cyc_ocp_i), .trip_o(trips[4]));

  prot_cycle_counter #(.LIMIT(DMAX_RUN), .UPDOWN(1'b0)) u_dmax_cnt (
    .clk(clk), .rst_n(rst_n), .en(sw_active), .cyc_i(cyc_end_i),
    .hit_i(cyc_dmax_i), .trip_o(trips[5]));

  assign trip_any     = |trips;
  assign trip_cause   = pick_cause(trips);
  assign ss_step_done = (tmr == TW'(SS_STEP_CLK - 1));
  assign wait_last    = (cause == C_DIS) ? TW'(DIS_RESTART_CLK - 1) : TW'(RESTART_CLK - 1);
  assign wait_done    = (tmr == wait_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      tmr   <= '0;
      step  <= '0;
      cause <= C_NONE;
    end else if (!start_i) begin
      state <= S_OFF;
      tmr   <= '0;
      step  <= '0;
      cause <= C_NONE;
    end else begin
      unique case (state)
        S_OFF: begin
          state <= S_SOFT;
          tmr   <= '0;
          step  <= '0;
        end
        S_SOFT, S_RUN: begin
          if (trip_any) begin
            state <= S_WAIT;
            tmr   <= '0;
            cause <= trip_cause;
          end else if (state == S_SOFT) begin
            if (ss_step_done) begin
              tmr <= '0;
              if (step == TOP_LVL) begin
                state <= S_RUN;
                cause <= C_NONE;
              end else begin
                step <= step + 1'b1;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (wait_done) begin
            tmr   <= '0;
            step  <= '0;
            state <= (cause == C_THERM) ? S_PROBE : S_SOFT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_PROBE: begin
          if (cyc_end_i) begin
            tmr   <= '0;
            step  <= '0;
            state <= ot_i ? S_WAIT : S_SOFT;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end

  assign pwm_en_o   = sw_active || (state == S_PROBE);
  assign ilim_lvl_o = sw_active ? step : '0;
  assign probe_o    = (state == S_PROBE);
  assign cause_o    = cause;
endmodule

// File: rtl/prot_restart_seq_chk.sv
module prot_restart_seq_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             pwm_en_o,
  input logic [LVL_W-1:0] ilim_lvl_o,
  input logic             probe_o,
  input logic [2:0]       cause_o,
  input logic             trip_any
);
  // R1: loss of start stops switching on the next edge
  a_r1_stop_on_start_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!pwm_en_o && cause_o == 3'd0));

  // R2: the soft-start level never falls while switching continues
  a_r2_level_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en_o && $past(pwm_en_o)) |-> (ilim_lvl_o >= $past(ilim_lvl_o)));

  // R2: no current-limit level is presented while the switch is disabled
  a_r2_level_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en_o |-> (ilim_lvl_o == '0));

  // R7: a qualified fault always removes the PWM enable on the next edge
  a_r7_trip_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_any && start_i) |=> !pwm_en_o);

  // R8: a probe cycle only exists on the way back from a thermal trip
  a_r8_probe_is_thermal: assert property (@(posedge clk) disable iff (!rst_n)
    probe_o |-> (cause_o == 3'd1 && pwm_en_o));

  // R10: a stop without loss of start leaves a cause behind
  a_r10_cause_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_en_o) && $past(start_i)) |-> (cause_o != 3'd0));
endmodule

bind prot_restart_seq prot_restart_seq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwm_en_o(pwm_en_o),
  .ilim_lvl_o(ilim_lvl_o), .probe_o(probe_o), .cause_o(cause_o),
  .trip_any(trip_any));

// File: tb/prot_restart_seq_tb.sv
module prot_restart_seq_tb;
  localparam int OVL = 6, DMR = 10, CLH = 5, DSH = 8;
  localparam int RST = 40, DRST = 20, SSC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cyc = 0, ocp = 0, dmx = 0, clamp = 0, dis = 0, ot = 0, flr = 0;
  logic pwm_en, probe;
  logic [2:0] lvl, cause;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  prot_restart_seq #(
    .LVL_W(3), .OVL_CYC(OVL), .DMAX_RUN(DMR), .CLAMP_HOLD(CLH), .DIS_HOLD(DSH),
    .RESTART_CLK(RST), .DIS_RESTART_CLK(DRST), .SS_STEP_CLK(SSC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cyc_end_i(cyc), .cyc_ocp_i(ocp),
    .cyc_dmax_i(dmx), .clamp_i(clamp), .dis_i(dis), .ot_i(ot), .floor_to_i(flr),
    .pwm_en_o(pwm_en), .ilim_lvl_o(lvl), .probe_o(probe), .cause_o(cause));

  // ---------------- behavioural reference ----------------
  localparam int P_OFF = 0, P_SOFT = 1, P_RUN = 2, P_WAIT = 3, P_PROBE = 4;
  int ph = P_OFF, tm = 0, st = 0, mc = 0;
  int n_ovl = 0, n_dm = 0, n_cl = 0, n_ds = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = P_OFF; tm = 0; st = 0; mc = 0;
      n_ovl = 0; n_dm = 0; n_cl = 0; n_ds = 0;
    end else begin
      bit act, inrun;
      int nc, wl;
      act   = (ph == P_SOFT) || (ph == P_RUN);
      inrun = (ph == P_RUN);
      nc = 0;
      if (act && cyc && dmx && n_dm == DMR - 1) nc = 6;
      if (act && cyc && ocp && n_ovl == OVL - 1) nc = 5;
      if (act && flr) nc = 4;
      if (inrun && clamp && n_cl == CLH) nc = 3;
      if (act && dis && n_ds == DSH) nc = 2;
      if (act && ot) nc = 1;
      n_ds = (act && dis) ? ((n_ds < DSH) ? n_ds + 1 : n_ds) : 0;
      n_cl = (inrun && clamp) ? ((n_cl < CLH) ? n_cl + 1 : n_cl) : 0;
      if (!act) begin n_ovl = 0; n_dm = 0; end
      else if (cyc) begin
        n_ovl = ocp ? n_ovl + 1 : ((n_ovl > 0) ? n_ovl - 1 : 0);
        n_dm  = dmx ? n_dm + 1 : 0;
      end
      wl = (mc == 2) ? DRST : RST;
      if (!start) begin
        ph = P_OFF; tm = 0; st = 0; mc = 0;
      end else if (ph == P_OFF) begin
        ph = P_SOFT; tm = 0; st = 0;
      end else if (act && nc != 0) begin
        ph = P_WAIT; tm = 0; mc = nc;
      end else if (ph == P_SOFT) begin
        tm++;
        if (tm == SSC) begin
          tm = 0;
          if (st == 7) begin ph = P_RUN; mc = 0; end else st++;
        end
      end else if (ph == P_WAIT) begin
        tm++;
        if (tm == wl) begin tm = 0; st = 0; ph = (mc == 1) ? P_PROBE : P_SOFT; end
      end else if (ph == P_PROBE) begin
        if (cyc) begin tm = 0; st = 0; ph = ot ? P_WAIT : P_SOFT; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_pwm;
      int e_lvl;
      e_pwm = (ph == P_SOFT) || (ph == P_RUN) || (ph == P_PROBE);
      e_lvl = ((ph == P_SOFT) || (ph == P_RUN)) ? st : 0;
      check(pwm_en == e_pwm, cur_req, "pwm_en", pwm_en, e_pwm);
      check(int'(lvl) == e_lvl, cur_req, "ilim_lvl", lvl, e_lvl);
      check(probe == (ph == P_PROBE), cur_req, "probe", probe, ph == P_PROBE);
      check(int'(cause) == mc, cur_req, "cause", cause, mc);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_cycle(input bit o, input bit d);
    @(negedge clk); cyc = 1; ocp = o; dmx = d;
    @(negedge clk); cyc = 0; ocp = 0; dmx = 0;
  endtask

  task automatic hold_level(ref logic sig, input int n);
    @(negedge clk); sig = 1;
    repeat (n) @(negedge clk);
    sig = 0;
  endtask

  // counts clocks with pwm low, starting at the current negedge
  task automatic measure_off(output int n);
    n = 0;
    while (!pwm_en) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    idle(3);
    rst_n = 1;
    idle(2);
    cur_req = "R1";
    check(!pwm_en && lvl == 0 && cause == 0, "R1", "idle without start", pwm_en, 0);

    // R2 soft-start ramp
    cur_req = "R2";
    @(negedge clk); start = 1;
    @(negedge clk);
    check(pwm_en && lvl == 0, "R2", "first soft-start level", lvl, 0);
    idle(SSC);
    check(lvl == 1, "R2", "second soft-start level", lvl, 1);
    idle(8 * SSC);
    check(lvl == 7 && cause == 0, "R2", "run at full level", lvl, 7);

    // R3 overload with saturation at zero
    cur_req = "R3";
    repeat (3) one_cycle(0, 0);
    repeat (5) one_cycle(1, 0);
    check(pwm_en == 1, "R3", "net count 5 no trip", pwm_en, 1);
    one_cycle(0, 0);
    one_cycle(1, 0);
    check(pwm_en == 1, "R3", "net count 5 after decrement", pwm_en, 1);
    one_cycle(1, 0);
    check(!pwm_en && cause == 5, "R3", "overload cause", cause, 5);

    // R7 restart wait length
    cur_req = "R7";
    measure_off(n);
    check(n == RST, "R7", "restart wait clocks", n, RST);
    check(lvl == 0 && cause == 5, "R7", "restart from level 0", lvl, 0);
    idle(8 * SSC + 2);

    // R4 max duty run
    cur_req = "R4";
    repeat (9) one_cycle(0, 1);
    one_cycle(0, 0);
    repeat (9) one_cycle(0, 1);
    check(pwm_en == 1, "R4", "broken run no trip", pwm_en, 1);
    one_cycle(0, 1);
    check(!pwm_en && cause == 6, "R4", "max duty cause", cause, 6);

    // R5 clamp ignored in soft-start, debounced in run
    cur_req = "R5";
    while (!pwm_en) @(negedge clk);
    hold_level(clamp, 20);
    check(pwm_en == 1, "R5", "clamp ignored in soft-start", pwm_en, 1);
    idle(8 * SSC);
    hold_level(clamp, CLH);
    idle(2);
    check(pwm_en == 1, "R5", "clamp at hold no trip", pwm_en, 1);
    hold_level(clamp, CLH + 1);
    check(!pwm_en && cause == 3, "R5", "clamp cause", cause, 3);
    while (!pwm_en) @(negedge clk);
    idle(8 * SSC + 2);

    // R6 disable debounce and short wait
    cur_req = "R6";
    hold_level(dis, DSH);
    idle(2);
    check(pwm_en == 1, "R6", "disable at hold no trip", pwm_en, 1);
    hold_level(dis, DSH + 1);
    check(!pwm_en && cause == 2, "R6", "disable cause", cause, 2);
    measure_off(n);
    check(n == DRST, "R6", "disable restart clocks", n, DRST);
    idle(8 * SSC + 2);

    // R8 thermal probe
    cur_req = "R8";
    @(negedge clk); ot = 1;
    @(negedge clk);
    check(!pwm_en && cause == 1, "R8", "thermal cause", cause, 1);
    while (!probe) @(negedge clk);
    check(pwm_en && lvl == 0, "R8", "probe enables switch", pwm_en, 1);
    one_cycle(0, 0);
    check(!pwm_en && !probe, "R8", "still hot waits again", pwm_en, 0);
    while (!probe) @(negedge clk);
    @(negedge clk); ot = 0;
    one_cycle(0, 0);
    check(pwm_en && !probe && lvl == 0, "R8", "cool probe enters soft-start", probe, 0);
    cur_req = "R10";
    check(cause == 1, "R10", "cause held through soft-start", cause, 1);
    idle(8 * SSC + 1);
    check(cause == 0, "R10", "cause cleared after soft-start", cause, 0);

    // R9 floor timeout
    cur_req = "R9";
    hold_level(flr, 1);
    check(!pwm_en && cause == 4, "R9", "floor cause", cause, 4);
    while (!pwm_en) @(negedge clk);
    idle(8 * SSC + 2);

    // R10 priority of coincident trips
    cur_req = "R10";
    @(negedge clk); ot = 1; flr = 1;
    @(negedge clk); ot = 0; flr = 0;
    check(cause == 1, "R10", "thermal beats floor", cause, 1);
    while (!probe) @(negedge clk);
    one_cycle(0, 0);
    idle(4);

    // R1 loss of start
    cur_req = "R1";
    @(negedge clk); start = 0;
    @(negedge clk);
    check(!pwm_en && cause == 0 && lvl == 0, "R1", "start loss stops at once", pwm_en, 0);
    idle(3);
    finish_run();
  end
endmodule